// File: doc/BRIEF.md
# Interrupt Cause Register with Fatal-Error DMA Hold

This block is the 32-bit interrupt cause register of a network controller's register interface. Internal sources send single-cycle event pulses. Each pulse sets a sticky cause bit. A level interrupt request is raised while any cause bit is set and its mask-enable bit is also set. The mask value comes from a neighbouring register and enters as an input.

Software can acknowledge events in two ways:
- A read strobe returns the current bits and then clears all of them.
- A write clears every bit that is written as one.

When an event pulse meets a clear in the same cycle, the event wins, so no event is lost.

Three cause bits have fixed meanings:
- Bit 28 records an internal bus error, raised during either a target or a host transaction.
- Bit 27 records an uncorrectable (multi-bit) ECC error from the statistics memory. Corrected single-bit errors do not reach this block at all. A bit-27 event also latches a DMA-block output, which stops all further DMA reads and writes. That output is released only by the soft-reset input or by hardware reset.
- Bit 26 records a parity error in the packet filter buffers. It is non-fatal, and reading the separate memory-error status register also clears it.

Bits 23 to 0 take general event sources, one per bit.

Top module: `irq_cause_reg`

## Requirements
- R1: During and after hardware reset (rst_ni low), the register reads zero, irq_o is 0 and dma_block_o is 0.
- R2: An event pulse sets its cause bit at the next clock edge, and the bit holds until it is cleared. Bit positions: gen_evt_i[i] sets bit i for i = 0..23, filt_par_evt_i sets bit 26, ecc_fatal_evt_i sets bit 27 and bus_err_evt_i sets bit 28.
- R3: Bits 31 to 29 and 25 to 24 always read as zero, whatever is written to them.
- R4: While rd_en_i is high, rd_data_o shows the value before the clear. After that clock edge, every cause bit is zero unless an event arrived in the same cycle.
- R5: A write with wr_en_i clears each bit whose wr_data_i bit is 1 and leaves each bit whose wr_data_i bit is 0 unchanged.
- R6: An event pulse in the same cycle as a read clear, a write-one clear or a status-read clear leaves its bit set.
- R7: A pulse on mem_err_rd_i clears bit 26 only and leaves every other bit unchanged.
- R8: irq_o is 1 exactly when (rd_data_o & mask_i) is nonzero.
- R9: ecc_fatal_evt_i sets dma_block_o at the next edge. dma_block_o stays set through reads and writes of the cause register. A soft_rst_i pulse clears it, unless a fatal event arrives in the same cycle. soft_rst_i never changes the cause bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gen_evt_i | input | 24 | General event pulses, bits 23..0 |
| filt_par_evt_i | input | 1 | Filter buffer parity error pulse (bit 26) |
| ecc_fatal_evt_i | input | 1 | Uncorrectable statistics-memory ECC error pulse (bit 27) |
| bus_err_evt_i | input | 1 | Internal bus error pulse (bit 28) |
| rd_en_i | input | 1 | Single-cycle read strobe of the cause register |
| wr_en_i | input | 1 | Write strobe of the cause register |
| wr_data_i | input | 32 | Write data; ones clear bits |
| mem_err_rd_i | input | 1 | Read strobe of the memory-error status register |
| mask_i | input | 32 | Interrupt enable mask |
| soft_rst_i | input | 1 | Device soft reset pulse |
| rd_data_o | output | 32 | Current cause value |
| irq_o | output | 1 | Interrupt request |
| dma_block_o | output | 1 | DMA reads and writes blocked |

## Verification
The assertions check on every cycle that:
- the reserved bits read zero;
- the interrupt tracks the masked cause value;
- the named sources set their bits at the next edge;
- a read with no event leaves the register empty;
- the DMA hold persists until a soft reset.

Only the bench scenarios show the following:
- the per-bit mapping of all 24 general sources;
- the exact clearing of a write pattern;
- that the status-register read clears only the parity bit;
- that the pre-clear value is returned during the read strobe.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int REG_W         = 32;
  localparam int GEN_W         = 24;
  localparam int BIT_FILT_PAR  = 26;
  localparam int BIT_ECC_FATAL = 27;
  localparam int BIT_BUS_ERR   = 28;
  localparam logic [REG_W-1:0] IMPL_MASK =
    (REG_W'(1) << BIT_BUS_ERR) | (REG_W'(1) << BIT_ECC_FATAL) |
    (REG_W'(1) << BIT_FILT_PAR) | ((REG_W'(1) << GEN_W) - REG_W'(1));
endpackage

// File: rtl/irq_cause_core.sv
module irq_cause_core
  import irq_cause_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] cause_o
);
  logic [REG_W-1:0] cause_q;

  // set has priority over clear; unimplemented bits never hold state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= ((cause_q & ~clr_i) | set_i) & IMPL_MASK;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/irq_dma_hold.sv
module irq_dma_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rel_i,
  output logic hold_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= set_i | (hold_q & ~rel_i);
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/irq_mask_reduce.sv
module irq_mask_reduce #(
  parameter int W = 32
) (
  input  logic [W-1:0] cause_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  assign irq_o = |(cause_i & mask_i);
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
  import irq_cause_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GEN_W-1:0] gen_evt_i,
  input  logic             filt_par_evt_i,
  input  logic             ecc_fatal_evt_i,
  input  logic             bus_err_evt_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             mem_err_rd_i,
  input  logic [REG_W-1:0] mask_i,
  input  logic             soft_rst_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o,
  output logic             dma_block_o
);
  logic [REG_W-1:0] set_vec, clr_vec, cause;

  always_comb begin
    set_vec = '0;
    set_vec[GEN_W-1:0]    = gen_evt_i;
    set_vec[BIT_FILT_PAR]  = filt_par_evt_i;
    set_vec[BIT_ECC_FATAL] = ecc_fatal_evt_i;
    set_vec[BIT_BUS_ERR]   = bus_err_evt_i;
  end

  always_comb begin
    if (rd_en_i)      clr_vec = '1;
    else if (wr_en_i) clr_vec = wr_data_i;
    else              clr_vec = '0;
    clr_vec[BIT_FILT_PAR] = clr_vec[BIT_FILT_PAR] | mem_err_rd_i;
  end

  irq_cause_core u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .cause_o(cause)
  );

  irq_dma_hold u_dma (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ecc_fatal_evt_i),
    .rel_i (soft_rst_i),
    .hold_o(dma_block_o)
  );

  irq_mask_reduce #(.W(REG_W)) u_irq (
    .cause_i(cause),
    .mask_i (mask_i),
    .irq_o  (irq_o)
  );

  assign rd_data_o = cause;
endmodule

// File: rtl/irq_cause_reg_chk.sv
module irq_cause_reg_chk
  import irq_cause_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [GEN_W-1:0] gen_evt_i,
  input logic             filt_par_evt_i,
  input logic             ecc_fatal_evt_i,
  input logic             bus_err_evt_i,
  input logic             rd_en_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             mem_err_rd_i,
  input logic [REG_W-1:0] mask_i,
  input logic             soft_rst_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             irq_o,
  input logic             dma_block_o
);
  logic any_evt;
  assign any_evt = (|gen_evt_i) | filt_par_evt_i | ecc_fatal_evt_i | bus_err_evt_i;

  always_comb begin
    if (rst_ni) begin
      assert_reserved_zero_R3: assert (rd_data_o[31:29] == 3'b0 && rd_data_o[25:24] == 2'b0);
      assert_irq_masked_R8: assert (irq_o == |(rd_data_o & mask_i));
    end
  end

  assert_bus_err_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_evt_i |=> rd_data_o[BIT_BUS_ERR]);

  assert_fatal_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_fatal_evt_i |=> rd_data_o[BIT_ECC_FATAL]);

  assert_read_empties_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !any_evt) |=> rd_data_o == '0);

  assert_write_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !any_evt) |=> (rd_data_o & $past(wr_data_i)) == '0);

  assert_dma_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_fatal_evt_i |=> dma_block_o);

  assert_dma_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_block_o && !soft_rst_i) |=> dma_block_o);

  assert_status_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_err_rd_i && !filt_par_evt_i) |=> !rd_data_o[BIT_FILT_PAR]);
endmodule

bind irq_cause_reg irq_cause_reg_chk u_chk (.*);

// File: tb/irq_cause_reg_test.sv
`timescale 1ns/1ps
module irq_cause_reg_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] gen_evt_i = '0;
  logic        filt_par_evt_i = 1'b0, ecc_fatal_evt_i = 1'b0, bus_err_evt_i = 1'b0;
  logic        rd_en_i = 1'b0, wr_en_i = 1'b0, mem_err_rd_i = 1'b0, soft_rst_i = 1'b0;
  logic [31:0] wr_data_i = '0, mask_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o, dma_block_o;

  int checks = 0, fails = 0;

  irq_cause_reg uut (.*);

  always #5 clk_i = ~clk_i;

  localparam logic [31:0] IMPL = 32'h1CFF_FFFF;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    gen_evt_i = '0; filt_par_evt_i = 0; ecc_fatal_evt_i = 0; bus_err_evt_i = 0;
    rd_en_i = 0; wr_en_i = 0; wr_data_i = '0; mem_err_rd_i = 0; soft_rst_i = 0;
  endtask

  task automatic drive_src(int p);
    if (p < 24)       gen_evt_i[p] = 1'b1;
    else if (p == 26) filt_par_evt_i = 1'b1;
    else if (p == 27) ecc_fatal_evt_i = 1'b1;
    else if (p == 28) bus_err_evt_i = 1'b1;
  endtask

  task automatic clear_all();
    rd_en_i = 1; tick(); idle();
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] e;
    @(negedge clk_i);
    mask_i = '1;
    chk("R1 reset data", rd_data_o, '0);
    chk("R1 reset irq", {31'b0, irq_o}, 0);
    chk("R1 reset dma", {31'b0, dma_block_o}, 0);
    tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 after reset", rd_data_o, '0);

    // per-bit sweep: set, mask, write-0 keep, write-1 clear
    for (int p = 0; p < 32; p++) begin
      e = IMPL & (32'h1 << p);
      drive_src(p); tick(); idle();
      chk("R2 R3 set bit", rd_data_o, e);
      mask_i = 32'h1 << p;
      #1 chk("R8 mask hit", {31'b0, irq_o}, {31'b0, e != 0});
      mask_i = ~(32'h1 << p);
      #1 chk("R8 mask miss", {31'b0, irq_o}, 0);
      wr_en_i = 1; wr_data_i = ~(32'h1 << p); tick(); idle();
      chk("R5 write zero keeps", rd_data_o, e);
      wr_en_i = 1; wr_data_i = 32'h1 << p; tick(); idle();
      chk("R5 write one clears", rd_data_o, '0);
      soft_rst_i = 1; tick(); idle();
    end
    mask_i = '1;

    // R3 writes of ones into reserved bits do not appear
    wr_en_i = 1; wr_data_i = '1; tick(); idle();
    chk("R3 reserved write", rd_data_o, '0);

    // R4 read returns pre-clear value, then empties
    gen_evt_i = 24'hA5_0F0F; bus_err_evt_i = 1; filt_par_evt_i = 1; tick(); idle();
    e = 32'h14A5_0F0F;
    rd_en_i = 1;
    #1 chk("R4 read data during strobe", rd_data_o, e);
    tick(); idle();
    chk("R4 cleared after read", rd_data_o, '0);

    // R5 partial pattern
    gen_evt_i = 24'hFF_FFFF; tick(); idle();
    wr_en_i = 1; wr_data_i = 32'h0033_CC55; tick(); idle();
    chk("R5 pattern clear", rd_data_o, 32'h00FF_FFFF & ~32'h0033_CC55);
    clear_all();

    // R6 set beats read clear
    gen_evt_i = 24'h00_0003; tick(); idle();
    rd_en_i = 1; bus_err_evt_i = 1; tick(); idle();
    chk("R6 set wins over read", rd_data_o, 32'h1000_0000);
    wr_en_i = 1; wr_data_i = 32'h1000_0000; bus_err_evt_i = 1; tick(); idle();
    chk("R6 set wins over write", rd_data_o, 32'h1000_0000);
    clear_all();

    // R7 status read clears bit 26 only
    filt_par_evt_i = 1; gen_evt_i = 24'h20; bus_err_evt_i = 1; tick(); idle();
    mem_err_rd_i = 1; tick(); idle();
    chk("R7 status read clears parity", rd_data_o, 32'h1000_0020);
    mem_err_rd_i = 1; filt_par_evt_i = 1; tick(); idle();
    chk("R6 R7 set wins over status read", rd_data_o, 32'h1400_0020);
    clear_all();
    chk("R8 no cause no irq", {31'b0, irq_o}, 0);

    // R9 dma hold
    ecc_fatal_evt_i = 1; tick(); idle();
    chk("R9 dma set", {31'b0, dma_block_o}, 1);
    chk("R9 fatal bit", rd_data_o, 32'h0800_0000);
    rd_en_i = 1; tick(); idle();
    wr_en_i = 1; wr_data_i = '1; tick(); idle();
    chk("R9 dma holds over rd/wr", {31'b0, dma_block_o}, 1);
    gen_evt_i = 24'h1; tick(); idle();
    soft_rst_i = 1; tick(); idle();
    chk("R9 soft reset releases", {31'b0, dma_block_o}, 0);
    chk("R9 soft reset keeps cause", rd_data_o, 32'h1);
    soft_rst_i = 1; ecc_fatal_evt_i = 1; tick(); idle();
    chk("R9 fatal beats soft reset", {31'b0, dma_block_o}, 1);
    rst_ni = 0; #1;
    chk("R1 hw reset clears dma", {31'b0, dma_block_o}, 0);
    chk("R1 hw reset clears cause", rd_data_o, '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule